// File: doc/BRIEF.md
# Multi-Page-Size DMA Translation Cache

This block caches address translations for a DMA remapping unit. Each cached entry belongs to one requester (a 16-bit source ID) and one domain. It covers a page of 4 KiB, 2 MiB or 1 GiB, chosen by its paging level. A requester presents its source ID and a 39-bit guest physical address. The cache tries the three page granularities in turn, smallest first. It returns hit or miss and, on a hit, four results: the page-aligned input base, the page-aligned translated base, the in-page offset mask and a two-bit permission.

The page walker installs new translations through a fill port. A fill that matches an existing entry on source ID, level and frame number overwrites that entry. Otherwise the fill takes the first free slot. When every slot is full, the fill first empties the whole cache.

Entries are removed through one invalidation port, which has three kinds:
- global, which removes every entry;
- domain, which removes every entry of one domain;
- page-selective, which takes an address and a mask order and removes matching entries of one domain.

The page-selective kind removes an entry in two cases. In the first, the entry's frame falls inside the aligned range the invalidation names. In the second, the invalidation address falls inside the entry's large page. Invalidation always takes precedence over a lookup probe or a fill issued in the same cycle.

Top module: `dma_xlate_cache`

## Requirements
- R1: After reset the cache holds no entry. `lk_busy` and `lk_done` are 0, and any lookup misses.
- R2: A fill installs one entry tagged with source ID, domain, level and frame. The level encoding is 1 = 4 KiB, 2 = 2 MiB and 3 = 1 GiB; 0 is not allowed. The frame is (address AND page mask) >> 12. A fill whose source ID, level and frame equal those of a valid entry replaces that entry.
- R3: A lookup is accepted on a clock edge where `lk_req` is high and the cache is idle. The first cycle after acceptance probes level 1, the next probes level 2 and the one after probes level 3. `lk_done` pulses for one cycle with the result of the first level that matches, so a level-L hit reports L cycles after acceptance. A miss reports after 3 cycles, with all result outputs at zero.
- R4: On a hit at level L, take the page mask m as all ones shifted left by 12 + 9*(L-1). Then `lk_in_base` = address AND m, `lk_out_base` = stored translated base AND m, and `lk_addr_mask` = NOT m. `lk_perm` bit 1 means write allowed and bit 0 means read allowed.
- R5: `lk_busy` is high from acceptance until the edge that raises `lk_done`. While busy, `lk_req` has no effect.
- R6: An entry hits only for the source ID that filled it.
- R7: A page-selective invalidation (`inv_kind` = 2, order am from 0 to 18) removes an entry of domain `inv_did` when either of two tests holds. Test one: the entry frame and (`inv_addr` >> 12) are equal once both have their low am bits cleared. Test two: the entry frame equals (`inv_addr` AND the entry's page mask) >> 12.
- R8: A domain invalidation (`inv_kind` = 1) removes every entry whose domain equals `inv_did`, and no other entry.
- R9: A global invalidation (`inv_kind` = 0) removes every entry.
- R10: In a cycle where `inv_req` is high, a pending lookup probe does not advance. The same level is probed in the next cycle, against the contents left after the invalidation.
- R11: A fill presented in the same cycle as `inv_req` is installed in the following cycle, after the invalidation has taken effect.
- R12: A fill that matches no entry while every slot is valid first removes all entries, then installs itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_sid | input | 16 | Lookup source ID |
| lk_addr | input | 39 | Lookup guest physical address |
| lk_busy | output | 1 | Lookup in progress |
| lk_done | output | 1 | One-cycle result strobe |
| lk_hit | output | 1 | Result is a hit |
| lk_in_base | output | 39 | Page-aligned input address |
| lk_out_base | output | 39 | Page-aligned translated address |
| lk_addr_mask | output | 39 | In-page offset mask |
| lk_perm | output | 2 | Bit 1 write, bit 0 read |
| fill_req | input | 1 | Install an entry |
| fill_sid | input | 16 | Fill source ID |
| fill_did | input | 16 | Fill domain ID |
| fill_addr | input | 39 | Guest address covered by the fill |
| fill_level | input | 2 | Paging level, 1 to 3 |
| fill_xbase | input | 39 | Translated base from the leaf entry |
| fill_perm | input | 2 | Bit 1 write, bit 0 read |
| inv_req | input | 1 | Invalidation request |
| inv_kind | input | 2 | 0 global, 1 domain, 2 page-selective |
| inv_did | input | 16 | Domain to invalidate |
| inv_addr | input | 39 | Page-selective address |
| inv_am | input | 5 | Page-selective mask order, 0 to 18 |

## Verification
Lookups sweep many offsets inside one page of each size. This shows that every offset bit is masked away and that the latency tracks the level. Overlapping 4 KiB and 2 MiB pages for one requester, probed inside and outside the small page, tell probe order apart from any other order. Page-selective invalidations use three kinds of address: one aligned range covering a small page, one unaligned address inside a large page, and one with a foreign domain. Together these separate the two removal tests and the domain filter. Invalidations placed during a probe or alongside a fill, and a fill into a full cache, exercise the ordering rules.

// File: rtl/xc_pkg.sv
package xc_pkg;
   localparam int unsigned PG_SHIFT = 12;
   localparam int unsigned LVL_BITS = 9;

   localparam logic [1:0] INV_ALL  = 2'd0;
   localparam logic [1:0] INV_DOM  = 2'd1;
   localparam logic [1:0] INV_PAGE = 2'd2;

   // low address bit of a page at the given level (1=4K, 2=2M, 3=1G)
   function automatic int unsigned lvl_shift(input logic [1:0] lvl);
      case (lvl)
         2'd2:    return PG_SHIFT + LVL_BITS;
         2'd3:    return PG_SHIFT + 2 * LVL_BITS;
         default: return PG_SHIFT;
      endcase
   endfunction
endpackage

// File: rtl/xc_entry.sv
module xc_entry #(
   parameter int ADDR_W = 39,
   parameter int SID_W  = 16,
   parameter int DID_W  = 16,
   parameter int AM_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wipe,
   input  logic [SID_W-1:0]  w_sid,
   input  logic [DID_W-1:0]  w_did,
   input  logic [1:0]        w_lvl,
   input  logic [ADDR_W-1:0] w_addr,
   input  logic [ADDR_W-1:0] w_xbase,
   input  logic [1:0]        w_perm,
   input  logic              inv_go,
   input  logic [1:0]        inv_kind,
   input  logic [DID_W-1:0]  inv_did,
   input  logic [ADDR_W-1:0] inv_addr,
   input  logic [AM_W-1:0]   inv_am,
   input  logic [SID_W-1:0]  p_sid,
   input  logic [ADDR_W-1:0] p_addr,
   input  logic [1:0]        p_lvl,
   output logic              valid,
   output logic              key_hit,
   output logic              probe_hit,
   output logic [ADDR_W-1:0] xbase,
   output logic [1:0]        perm
);
   import xc_pkg::*;

   localparam int FN_W = ADDR_W - PG_SHIFT;

   function automatic logic [FN_W-1:0] frame_of(input logic [ADDR_W-1:0] a,
                                                input logic [1:0] lvl);
      logic [ADDR_W-1:0] ones;
      logic [ADDR_W-1:0] t;
      ones = '1;
      t = (a & (ones << lvl_shift(lvl))) >> PG_SHIFT;
      return t[FN_W-1:0];
   endfunction

   logic              e_v;
   logic [SID_W-1:0]  e_sid;
   logic [DID_W-1:0]  e_did;
   logic [1:0]        e_lvl;
   logic [FN_W-1:0]   e_frame;
   logic [ADDR_W-1:0] e_xbase;
   logic [1:0]        e_perm;

   logic [FN_W-1:0]   rmask;
   logic [FN_W-1:0]   ifn;
   logic              in_range;
   logic              in_large;
   logic              kill;

   always_comb begin
      rmask    = {FN_W{1'b1}} << inv_am;
      ifn      = inv_addr[ADDR_W-1:PG_SHIFT];
      in_range = (e_frame & rmask) == (ifn & rmask);
      in_large = e_frame == frame_of(inv_addr, e_lvl);
      kill     = inv_go && e_v &&
                 ((inv_kind == INV_ALL) ||
                  ((e_did == inv_did) &&
                   ((inv_kind == INV_DOM) ||
                    ((inv_kind == INV_PAGE) && (in_range || in_large)))));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              e_v <= 1'b0;
      else if (wr_en)          e_v <= 1'b1;
      else if (kill || wipe)   e_v <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         e_sid   <= w_sid;
         e_did   <= w_did;
         e_lvl   <= w_lvl;
         e_frame <= frame_of(w_addr, w_lvl);
         e_xbase <= w_xbase;
         e_perm  <= w_perm;
      end
   end

   assign valid     = e_v;
   assign key_hit   = e_v && (e_sid == w_sid) && (e_lvl == w_lvl) &&
                      (e_frame == frame_of(w_addr, w_lvl));
   assign probe_hit = e_v && (e_sid == p_sid) && (e_lvl == p_lvl) &&
                      (e_frame == frame_of(p_addr, p_lvl));
   assign xbase     = e_xbase;
   assign perm      = e_perm;
endmodule

// File: rtl/xc_alloc.sv
module xc_alloc #(
   parameter int N_ENTRIES = 16,
   localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic [N_ENTRIES-1:0] valid,
   input  logic [N_ENTRIES-1:0] key_hit,
   output logic [IDX_W-1:0]     slot,
   output logic                 wipe
);
   logic got_key;
   logic got_free;

   always_comb begin
      slot     = '0;
      got_key  = 1'b0;
      got_free = 1'b0;
      for (int i = 0; i < N_ENTRIES; i++) begin
         if (key_hit[i] && !got_key) begin
            slot    = IDX_W'(i);
            got_key = 1'b1;
         end
      end
      if (!got_key) begin
         for (int i = 0; i < N_ENTRIES; i++) begin
            if (!valid[i] && !got_free) begin
               slot     = IDX_W'(i);
               got_free = 1'b1;
            end
         end
      end
      wipe = !got_key && !got_free;
   end
endmodule

// File: rtl/dma_xlate_cache.sv
module dma_xlate_cache #(
   parameter int N_ENTRIES = 16,
   parameter int ADDR_W    = 39,
   parameter int SID_W     = 16,
   parameter int DID_W     = 16,
   parameter int MAX_AM    = 18,
   localparam int AM_W     = $clog2(MAX_AM + 1),
   localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [SID_W-1:0]  lk_sid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_busy,
   output logic              lk_done,
   output logic              lk_hit,
   output logic [ADDR_W-1:0] lk_in_base,
   output logic [ADDR_W-1:0] lk_out_base,
   output logic [ADDR_W-1:0] lk_addr_mask,
   output logic [1:0]        lk_perm,
   input  logic              fill_req,
   input  logic [SID_W-1:0]  fill_sid,
   input  logic [DID_W-1:0]  fill_did,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [1:0]        fill_level,
   input  logic [ADDR_W-1:0] fill_xbase,
   input  logic [1:0]        fill_perm,
   input  logic              inv_req,
   input  logic [1:0]        inv_kind,
   input  logic [DID_W-1:0]  inv_did,
   input  logic [ADDR_W-1:0] inv_addr,
   input  logic [AM_W-1:0]   inv_am
);
   import xc_pkg::*;

   generate
      if (N_ENTRIES < 1 || N_ENTRIES > 1024) begin : g_bad_depth
         $error("N_ENTRIES must lie in 1..1024");
      end
      if (ADDR_W < PG_SHIFT + 2 * LVL_BITS + 1) begin : g_bad_addr
         $error("ADDR_W too small for 1 GiB pages");
      end
      if (MAX_AM > ADDR_W - PG_SHIFT) begin : g_bad_am
         $error("MAX_AM exceeds frame width");
      end
   endgenerate

   typedef struct packed {
      logic [SID_W-1:0]  sid;
      logic [DID_W-1:0]  did;
      logic [1:0]        lvl;
      logic [ADDR_W-1:0] addr;
      logic [ADDR_W-1:0] xbase;
      logic [1:0]        perm;
   } fill_t;

   // fill path: a fill that meets an invalidation waits one cycle
   fill_t live_f, pend_f, use_f;
   logic  pend_v;
   logic  f_go;

   assign live_f = '{sid: fill_sid, did: fill_did, lvl: fill_level,
                     addr: fill_addr, xbase: fill_xbase, perm: fill_perm};
   assign use_f  = pend_v ? pend_f : live_f;
   assign f_go   = !inv_req && (pend_v || fill_req);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v <= 1'b0;
      end else if (inv_req) begin
         if (fill_req) begin
            pend_v <= 1'b1;
            pend_f <= live_f;
         end
      end else if (pend_v) begin
         pend_v <= fill_req;
         pend_f <= live_f;
      end
   end

   // lookup state
   logic              q_busy;
   logic [1:0]        q_lvl;
   logic [SID_W-1:0]  q_sid;
   logic [ADDR_W-1:0] q_addr;

   logic [N_ENTRIES-1:0] e_valid, e_key, e_probe;
   logic [ADDR_W-1:0]    e_xbase [N_ENTRIES];
   logic [1:0]           e_perm  [N_ENTRIES];
   logic [IDX_W-1:0]     slot;
   logic                 full_wipe;

   xc_alloc #(.N_ENTRIES(N_ENTRIES)) i_alloc (
      .valid(e_valid), .key_hit(e_key), .slot(slot), .wipe(full_wipe)
   );

   generate
      for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
         xc_entry #(.ADDR_W(ADDR_W), .SID_W(SID_W), .DID_W(DID_W),
                    .AM_W(AM_W)) i_ent (
            .clk(clk), .rst_n(rst_n),
            .wr_en(f_go && (slot == IDX_W'(i))),
            .wipe(f_go && full_wipe),
            .w_sid(use_f.sid), .w_did(use_f.did), .w_lvl(use_f.lvl),
            .w_addr(use_f.addr), .w_xbase(use_f.xbase), .w_perm(use_f.perm),
            .inv_go(inv_req), .inv_kind(inv_kind), .inv_did(inv_did),
            .inv_addr(inv_addr), .inv_am(inv_am),
            .p_sid(q_sid), .p_addr(q_addr), .p_lvl(q_lvl),
            .valid(e_valid[i]), .key_hit(e_key[i]), .probe_hit(e_probe[i]),
            .xbase(e_xbase[i]), .perm(e_perm[i])
         );
      end
   endgenerate

   logic              any_hit;
   logic [ADDR_W-1:0] sel_x;
   logic [1:0]        sel_p;
   logic [ADDR_W-1:0] ones, pmask;

   always_comb begin
      any_hit = 1'b0;
      sel_x   = '0;
      sel_p   = '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
         if (e_probe[i] && !any_hit) begin
            any_hit = 1'b1;
            sel_x   = e_xbase[i];
            sel_p   = e_perm[i];
         end
      end
      ones  = '1;
      pmask = ones << lvl_shift(q_lvl);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_busy       <= 1'b0;
         q_lvl        <= 2'd1;
         q_sid        <= '0;
         q_addr       <= '0;
         lk_done      <= 1'b0;
         lk_hit       <= 1'b0;
         lk_in_base   <= '0;
         lk_out_base  <= '0;
         lk_addr_mask <= '0;
         lk_perm      <= '0;
      end else begin
         lk_done <= 1'b0;
         if (!q_busy) begin
            if (lk_req) begin
               q_busy <= 1'b1;
               q_lvl  <= 2'd1;
               q_sid  <= lk_sid;
               q_addr <= lk_addr;
            end
         end else if (!inv_req) begin
            if (any_hit) begin
               q_busy       <= 1'b0;
               lk_done      <= 1'b1;
               lk_hit       <= 1'b1;
               lk_in_base   <= q_addr & pmask;
               lk_out_base  <= sel_x & pmask;
               lk_addr_mask <= ~pmask;
               lk_perm      <= sel_p;
            end else if (q_lvl == 2'd3) begin
               q_busy       <= 1'b0;
               lk_done      <= 1'b1;
               lk_hit       <= 1'b0;
               lk_in_base   <= '0;
               lk_out_base  <= '0;
               lk_addr_mask <= '0;
               lk_perm      <= '0;
            end else begin
               q_lvl <= q_lvl + 2'd1;
            end
         end
      end
   end

   assign lk_busy = q_busy;
endmodule

// File: rtl/xc_checker.sv
module xc_checker #(
   parameter int ADDR_W = 39,
   parameter int MAX_AM = 18,
   parameter int AM_W   = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_busy,
   input logic              lk_done,
   input logic              lk_hit,
   input logic [ADDR_W-1:0] lk_in_base,
   input logic [ADDR_W-1:0] lk_out_base,
   input logic [ADDR_W-1:0] lk_addr_mask,
   input logic [1:0]        lk_perm,
   input logic              fill_req,
   input logic [1:0]        fill_level,
   input logic              inv_req,
   input logic [1:0]        inv_kind,
   input logic [AM_W-1:0]   inv_am
);
   a_r5_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
      lk_done |-> $past(lk_busy));

   a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      lk_done |-> !lk_busy);

   a_r4_bases_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_done && lk_hit) |-> (((lk_in_base & lk_addr_mask) == '0) &&
                               ((lk_out_base & lk_addr_mask) == '0)));

   a_r4_mask_size: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_done && lk_hit) |-> ($countones(lk_addr_mask) == 12 ||
                               $countones(lk_addr_mask) == 21 ||
                               $countones(lk_addr_mask) == 30));

   a_r3_miss_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_done && !lk_hit) |-> (lk_perm == 2'd0 && lk_addr_mask == '0 &&
                                lk_out_base == '0));

   a_r7_order_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_req && inv_kind == 2'd2) |-> (int'(inv_am) <= MAX_AM));

   a_r2_level_legal: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |-> (fill_level != 2'd0));
endmodule

bind dma_xlate_cache xc_checker #(.ADDR_W(ADDR_W), .MAX_AM(MAX_AM), .AM_W(AM_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .lk_busy(lk_busy), .lk_done(lk_done),
   .lk_hit(lk_hit), .lk_in_base(lk_in_base), .lk_out_base(lk_out_base),
   .lk_addr_mask(lk_addr_mask), .lk_perm(lk_perm), .fill_req(fill_req),
   .fill_level(fill_level), .inv_req(inv_req), .inv_kind(inv_kind),
   .inv_am(inv_am)
);

// File: tb/test_dma_xlate_cache.sv
`timescale 1ns/1ps
module test_dma_xlate_cache;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_req = 1'b0;
   logic [15:0] lk_sid = '0;
   logic [38:0] lk_addr = '0;
   logic        lk_busy, lk_done, lk_hit;
   logic [38:0] lk_in_base, lk_out_base, lk_addr_mask;
   logic [1:0]  lk_perm;
   logic        fill_req = 1'b0;
   logic [15:0] fill_sid = '0, fill_did = '0;
   logic [38:0] fill_addr = '0, fill_xbase = '0;
   logic [1:0]  fill_level = 2'd1, fill_perm = '0;
   logic        inv_req = 1'b0;
   logic [1:0]  inv_kind = '0;
   logic [15:0] inv_did = '0;
   logic [38:0] inv_addr = '0;
   logic [4:0]  inv_am = '0;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   dma_xlate_cache #(.N_ENTRIES(N)) i_dma_xlate_cache (.*);

   function automatic logic [38:0] pmask(input int lvl);
      logic [38:0] ones;
      ones = '1;
      return ones << (12 + 9 * (lvl - 1));
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic look(input logic [15:0] sid, input logic [38:0] a,
                       output bit hit, output logic [38:0] ib, output logic [38:0] ob,
                       output logic [38:0] mk, output logic [1:0] p, output int lat);
      bit busy_ok;
      busy_ok = 1'b1;
      lat = 0; hit = 0; ib = '0; ob = '0; mk = '0; p = '0;
      @(negedge clk);
      lk_req = 1'b1; lk_sid = sid; lk_addr = a;
      @(negedge clk);
      lk_req = 1'b0;
      for (int n = 1; n <= 10; n++) begin
         @(negedge clk);
         if (lk_done) begin
            lat = n; hit = lk_hit; ib = lk_in_base; ob = lk_out_base;
            mk = lk_addr_mask; p = lk_perm;
            if (lk_busy) busy_ok = 1'b0;
            break;
         end
         if (!lk_busy) busy_ok = 1'b0;
      end
      chk(busy_ok, "R5", "busy across lookup", 64'(busy_ok), 64'd1);
   endtask

   task automatic exp_hit(input string req, input logic [15:0] sid, input logic [38:0] a,
                          input int lvl, input logic [38:0] xb, input logic [1:0] pm);
      bit h; logic [38:0] ib, ob, mk, m; logic [1:0] p; int lat;
      look(sid, a, h, ib, ob, mk, p, lat);
      m = pmask(lvl);
      chk(h, req, "hit", 64'(h), 64'd1);
      chk(lat == lvl, req, "latency (R3)", 64'(lat), 64'(lvl));
      chk(ib == (a & m), req, "input base (R4)", 64'(ib), 64'(a & m));
      chk(ob == (xb & m), req, "output base (R4)", 64'(ob), 64'(xb & m));
      chk(mk == ~m, req, "addr mask (R4)", 64'(mk), 64'(~m));
      chk(p == pm, req, "perm (R4)", 64'(p), 64'(pm));
   endtask

   task automatic exp_miss(input string req, input logic [15:0] sid, input logic [38:0] a);
      bit h; logic [38:0] ib, ob, mk; logic [1:0] p; int lat;
      look(sid, a, h, ib, ob, mk, p, lat);
      chk(!h, req, "miss", 64'(h), 64'd0);
      chk(lat == 3, req, "miss latency (R3)", 64'(lat), 64'd3);
      chk(ob == '0 && p == '0, req, "miss outputs zero (R3)", 64'(ob), 64'd0);
   endtask

   task automatic fill(input logic [15:0] sid, input logic [15:0] did, input logic [38:0] a,
                       input logic [1:0] lvl, input logic [38:0] xb, input logic [1:0] pm);
      @(negedge clk);
      fill_req = 1'b1; fill_sid = sid; fill_did = did; fill_addr = a;
      fill_level = lvl; fill_xbase = xb; fill_perm = pm;
      @(negedge clk);
      fill_req = 1'b0;
   endtask

   task automatic inv(input logic [1:0] kind, input logic [15:0] did,
                      input logic [38:0] a, input logic [4:0] am);
      @(negedge clk);
      inv_req = 1'b1; inv_kind = kind; inv_did = did; inv_addr = a; inv_am = am;
      @(negedge clk);
      inv_req = 1'b0;
   endtask

   localparam logic [38:0] A4K = 39'h12_3456_7abc;
   localparam logic [38:0] X4K = 39'h07_0000_1000;
   localparam logic [38:0] A2M = 39'h23_4560_0000;
   localparam logic [38:0] X2M = 39'h01_0020_0000;
   localparam logic [38:0] A1G = 39'h40_0000_0000;
   localparam logic [38:0] X1G = 39'h00_8000_0000;

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!lk_busy && !lk_done, "R1", "idle after reset", {62'd0, lk_busy, lk_done}, 64'd0);
      exp_miss("R1", 16'd1, A4K);

      // R2 / R4: one page of each size, swept across offsets
      fill(16'd1, 16'd10, A4K, 2'd1, X4K, 2'd3);
      fill(16'd1, 16'd10, A2M, 2'd2, X2M, 2'd1);
      fill(16'd2, 16'd11, A1G, 2'd3, X1G, 2'd2);
      for (int k = 0; k < 6; k++) begin
         exp_hit("R4", 16'd1, (A4K & pmask(1)) | 39'((k * 32'h2af) & 32'hfff), 1, X4K, 2'd3);
         exp_hit("R4", 16'd1, A2M | 39'((k * 32'h3_3a55) & 32'h1f_ffff), 2, X2M, 2'd1);
         exp_hit("R4", 16'd2, A1G | 39'((k * 32'h1234_5677) & 32'h3fff_ffff), 3, X1G, 2'd2);
      end
      exp_miss("R3", 16'd1, A4K + 39'h1000);
      // R6: requester isolation
      exp_miss("R6", 16'd2, A4K);
      exp_miss("R6", 16'd1, A1G);

      // R3: probe order with overlapping 4K and 2M pages
      fill(16'd3, 16'd12, 39'h05_0020_0000, 2'd2, 39'h11_2200_0000, 2'd3);
      fill(16'd3, 16'd12, 39'h05_0020_3000, 2'd1, 39'h22_0000_5000, 2'd3);
      exp_hit("R3", 16'd3, 39'h05_0020_3abc, 1, 39'h22_0000_5000, 2'd3);
      exp_hit("R3", 16'd3, 39'h05_0020_5abc, 2, 39'h11_2200_0000, 2'd3);
      // R2: same key replaces
      fill(16'd3, 16'd12, 39'h05_0020_3fff, 2'd1, 39'h33_0000_9000, 2'd1);
      exp_hit("R2", 16'd3, 39'h05_0020_3010, 1, 39'h33_0000_9000, 2'd1);

      // R7: aligned range covers the 4K page, not the 2M page
      inv(2'd2, 16'd10, 39'h12_3456_4000, 5'd2);
      exp_miss("R7", 16'd1, A4K);
      exp_hit("R7", 16'd1, A2M, 2, X2M, 2'd1);
      // R7: foreign domain leaves the page in place
      inv(2'd2, 16'd99, A2M, 5'd0);
      exp_hit("R7", 16'd1, A2M | 39'h40, 2, X2M, 2'd1);
      // R7: unaligned address inside the large page removes it
      inv(2'd2, 16'd10, 39'h23_4567_8000, 5'd0);
      exp_miss("R7", 16'd1, A2M);

      // R8: domain-wide
      inv(2'd1, 16'd11, '0, 5'd0);
      exp_miss("R8", 16'd2, A1G);
      exp_hit("R8", 16'd3, 39'h05_0020_3010, 1, 39'h33_0000_9000, 2'd1);

      // R5: a request while busy has no effect
      begin
         int lat; bit h;
         lat = 0; h = 1'b1;
         @(negedge clk);
         lk_req = 1'b1; lk_sid = 16'd7; lk_addr = 39'h1000;
         @(negedge clk);
         lk_sid = 16'd3; lk_addr = 39'h05_0020_3010;
         for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            if (lk_done) begin lat = n; h = lk_hit; lk_req = 1'b0; break; end
         end
         lk_req = 1'b0;
         chk(!h && lat == 3, "R5", "request while busy ignored", {32'(lat), 31'd0, h}, 64'h3_0000_0000);
         @(negedge clk);
         chk(!lk_busy, "R5", "no second lookup started", 64'(lk_busy), 64'd0);
      end

      // R10: invalidation stalls the probe and wins
      begin
         int lat; bit h;
         lat = 0; h = 1'b1;
         @(negedge clk);
         lk_req = 1'b1; lk_sid = 16'd3; lk_addr = 39'h05_0020_3010;
         @(negedge clk);
         lk_req = 1'b0;
         inv_req = 1'b1; inv_kind = 2'd0;
         for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            inv_req = 1'b0;
            if (lk_done) begin lat = n; h = lk_hit; break; end
         end
         chk(!h, "R10", "probe sees invalidated state", 64'(h), 64'd0);
         chk(lat == 4, "R10", "stall adds one cycle", 64'(lat), 64'd4);
      end
      // R9: global removes everything
      exp_miss("R9", 16'd3, 39'h05_0020_5abc);

      // R11: fill alongside an invalidation lands afterwards
      fill(16'd4, 16'd20, 39'h00_0000_a000, 2'd1, 39'h00_0000_b000, 2'd3);
      @(negedge clk);
      inv_req = 1'b1; inv_kind = 2'd0;
      fill_req = 1'b1; fill_sid = 16'd4; fill_did = 16'd20;
      fill_addr = 39'h00_0000_c000; fill_level = 2'd1; fill_xbase = 39'h00_0000_d000; fill_perm = 2'd1;
      @(negedge clk);
      inv_req = 1'b0; fill_req = 1'b0;
      exp_miss("R11", 16'd4, 39'h00_0000_a000);
      exp_hit("R11", 16'd4, 39'h00_0000_c123, 1, 39'h00_0000_d000, 2'd1);

      // R12: full cache is emptied before a new fill
      inv(2'd0, '0, '0, 5'd0);
      for (int k = 0; k < N; k++)
         fill(16'd5, 16'd30, 39'(k) << 12, 2'd1, (39'(k) << 12) | 39'h10_0000_0000, 2'd3);
      exp_hit("R12", 16'd5, 39'h0_0000_0000, 1, 39'h10_0000_0000, 2'd3);
      exp_hit("R12", 16'd5, 39'(N - 1) << 12, 1, (39'(N - 1) << 12) | 39'h10_0000_0000, 2'd3);
      fill(16'd5, 16'd30, 39'(N) << 12, 2'd1, 39'h20_0000_0000, 2'd2);
      exp_miss("R12", 16'd5, 39'h0_0000_0000);
      exp_miss("R12", 16'd5, 39'(N - 1) << 12);
      exp_hit("R12", 16'd5, 39'(N) << 12, 1, 39'h20_0000_0000, 2'd2);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule